// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers interrupt sources for a small CPU and picks one at a time. The sources are one non-maskable line, eight external request lines and six internal peripheral request lines. It then offers the CPU a single request with a vector number and the byte address of that vector slot. Each external line can be set to respond to a low level or to a falling edge, and each can be switched on or off through a small register port. The CPU supplies its global mask bit and a pair of hints about instruction boundaries. When the CPU acknowledges an offer, the controller pulses an output that tells the CPU to set its mask bit.

A three-state machine runs the handshake. In IDLE nothing is offered. IDLE goes to OFFER when some unmasked request wins arbitration and no instruction-boundary hold is active. OFFER goes to GRANT when the CPU acknowledges. OFFER goes back to IDLE if the winner disappears before the acknowledge arrives. GRANT always returns to IDLE one cycle later. While in OFFER the registered vector follows the current winner. It is frozen from the acknowledge through GRANT. Edge-detected flags of the external lines outlive acceptance. Software removes them with a read-then-write-zero sequence.

Top module: `intc_top`

## Requirements
- R1: After reset `int_req` and `set_imask` are 0, and the sense register (select 0) and enable register (select 1) read as 0. Every line is therefore level-sensed and disabled.
- R2: A falling edge on `nmi_n` produces an offer with vector 3 whatever `cpu_imask` is. The offer outranks every other source. One edge is accepted once only.
- R3: Sense bit i = 0 makes `irq_n[i]` a request while it is low. Sense bit i = 1 makes a high-to-low transition on `irq_n[i]` set a flag that holds the request.
- R4: Enable bit i = 0 keeps line i from being offered. The status register (select 2) still shows its request at bit i.
- R5: While `cpu_imask` is 1, only the non-maskable source can be offered.
- R6: Priority runs from highest to lowest as follows: non-maskable, then `irq_n[0]` to `irq_n[7]` (a lower index wins), then `per_req[0]` to `per_req[5]`. The vectors are 3 for the non-maskable source, 4+i for `irq_n[i]` and 12+k for `per_req[k]`.
- R7: `int_vaddr` equals twice `int_vec`, because vector slots are two bytes wide and start at address 0.
- R8: An acknowledge while `int_req` is 1 produces a one-cycle `set_imask` pulse on the next cycle, with `int_req` low. `int_vec` does not change from the acknowledge through that pulse.
- R9: An edge flag survives acceptance. Writing 0 to its status bit clears it only if that bit was read as 1 since the flag was set. A write without such a read leaves the flag set.
- R10: While `cpu_mask_op` is 1, no new offer starts, but edges are still captured. After `cpu_mask_op` falls, offers resume only once `cpu_op_done` has pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| irq_n | input | 8 | External request lines, active low |
| per_req | input | 6 | Peripheral request flags, active high |
| cpu_imask | input | 1 | CPU global mask bit |
| cpu_mask_op | input | 1 | CPU is executing a mask-modifying instruction |
| cpu_op_done | input | 1 | CPU completed an instruction |
| cpu_ack | input | 1 | CPU accepts the offered vector |
| int_req | output | 1 | Offer to the CPU |
| int_vec | output | 5 | Offered vector number |
| int_vaddr | output | 6 | Byte address of the vector slot |
| set_imask | output | 1 | Pulse telling the CPU to set its mask bit |
| reg_sel | input | 2 | Register select: 0 sense, 1 enable, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
Suppose an edge flag is lost or cleared too early. Then an expected repeat offer never appears after unmasking, which shows up within a few cycles of the unmask. Suppose instead that a flag is stuck or the state machine fails to return to IDLE. Then an offer appears while the bench expects silence, or one is missing. A wrong priority encoding shows at once as the wrong vector on the first offer after simultaneous requests. A broken hold shows as an offer during the mask-modifying window.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_GRANT = 2'd2
    } intc_state_t;

    localparam int NMI_VEC      = 3;
    localparam int IRQ_VEC_BASE = 4;

    localparam logic [1:0] SEL_SENSE  = 2'd0;
    localparam logic [1:0] SEL_ENABLE = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_n,
    input  logic [N_IRQ-1:0] irq_n,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [N_IRQ-1:0] reg_wdata,
    input  logic             nmi_clr,
    output logic [N_IRQ-1:0] reg_rdata,
    output logic             nmi_pend,
    output logic [N_IRQ-1:0] irq_pend
);
    logic [N_IRQ-1:0] sense_r, enable_r, irq_q, edge_lat, armed;
    logic [N_IRQ-1:0] fall, clr_hit, status_view;
    logic             nmi_q, nmi_lat;
    logic             wr_stat, rd_stat;

    assign wr_stat     = reg_wr && (reg_sel == SEL_STATUS);
    assign rd_stat     = reg_rd && (reg_sel == SEL_STATUS);
    assign fall        = irq_q & ~irq_n;
    assign clr_hit     = {N_IRQ{wr_stat}} & ~reg_wdata & armed;
    assign status_view = (sense_r & edge_lat) | (~sense_r & ~irq_n);
    assign irq_pend    = status_view & enable_r;
    assign nmi_pend    = nmi_lat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_r  <= '0;
            enable_r <= '0;
            irq_q    <= '1;
            nmi_q    <= 1'b1;
            nmi_lat  <= 1'b0;
        end else begin
            irq_q <= irq_n;
            nmi_q <= nmi_n;
            if (reg_wr && reg_sel == SEL_SENSE)  sense_r  <= reg_wdata;
            if (reg_wr && reg_sel == SEL_ENABLE) enable_r <= reg_wdata;
            if (nmi_q && !nmi_n)  nmi_lat <= 1'b1;
            else if (nmi_clr)     nmi_lat <= 1'b0;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_IRQ; gi++) begin : g_line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    edge_lat[gi] <= 1'b0;
                    armed[gi]    <= 1'b0;
                end else if (!sense_r[gi]) begin
                    edge_lat[gi] <= 1'b0;
                    armed[gi]    <= 1'b0;
                end else if (fall[gi]) begin
                    edge_lat[gi] <= 1'b1;
                    armed[gi]    <= 1'b0;
                end else if (clr_hit[gi]) begin
                    edge_lat[gi] <= 1'b0;
                    armed[gi]    <= 1'b0;
                end else if (rd_stat && edge_lat[gi]) begin
                    armed[gi]    <= 1'b1;
                end
            end

            // R9
            edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_lat[gi] && sense_r[gi] && !reg_wr) |=> edge_lat[gi]);
        end
    endgenerate

    always_comb begin
        unique case (reg_sel)
            SEL_SENSE:  reg_rdata = sense_r;
            SEL_ENABLE: reg_rdata = enable_r;
            SEL_STATUS: reg_rdata = status_view;
            default:    reg_rdata = '0;
        endcase
    end

    // R2
    nmi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_lat && !nmi_clr) |=> nmi_lat);
endmodule

// File: rtl/intc_prio.sv
module intc_prio
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_PER = 6,
    parameter int VEC_W = 5
) (
    input  logic             nmi_pend,
    input  logic [N_IRQ-1:0] irq_pend,
    input  logic [N_PER-1:0] per_pend,
    input  logic             imask,
    input  logic             hold,
    output logic             win_any,
    output logic [VEC_W-1:0] win_vec
);
    localparam int PER_VEC_BASE = IRQ_VEC_BASE + N_IRQ;

    always_comb begin
        win_any = 1'b0;
        win_vec = '0;
        if (!hold) begin
            if (!imask) begin
                for (int k = N_PER - 1; k >= 0; k--) begin
                    if (per_pend[k]) begin
                        win_any = 1'b1;
                        win_vec = VEC_W'(PER_VEC_BASE + k);
                    end
                end
                for (int i = N_IRQ - 1; i >= 0; i--) begin
                    if (irq_pend[i]) begin
                        win_any = 1'b1;
                        win_vec = VEC_W'(IRQ_VEC_BASE + i);
                    end
                end
            end
            if (nmi_pend) begin
                win_any = 1'b1;
                win_vec = VEC_W'(NMI_VEC);
            end
        end
    end
endmodule

// File: rtl/intc_fsm.sv
module intc_fsm
    import intc_pkg::*;
#(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_any,
    input  logic [VEC_W-1:0] win_vec,
    input  logic             cpu_ack,
    input  logic             mask_op,
    input  logic             op_done,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             set_mask_o,
    output logic             nmi_clr,
    output logic             hold_any,
    output intc_state_t      state_o
);
    intc_state_t state, nxt;
    logic        hold_q;

    assign hold_any = hold_q || mask_op;
    assign state_o  = state;
    assign nmi_clr  = (state == ST_OFFER) && cpu_ack && (vec_o == VEC_W'(NMI_VEC));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (win_any) nxt = ST_OFFER;
            ST_OFFER: begin
                if (cpu_ack)       nxt = ST_GRANT;
                else if (!win_any) nxt = ST_IDLE;
            end
            ST_GRANT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_o      <= 1'b0;
            vec_o      <= '0;
            set_mask_o <= 1'b0;
            hold_q     <= 1'b0;
        end else begin
            req_o      <= (nxt == ST_OFFER);
            set_mask_o <= (state == ST_OFFER) && cpu_ack;
            if (nxt == ST_OFFER) vec_o <= win_vec;
            if (mask_op)      hold_q <= 1'b1;
            else if (op_done) hold_q <= 1'b0;
        end
    end

    // R8
    grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFFER && cpu_ack) |=> (set_mask_o && !req_o));
    // R8
    vec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask_o |-> $stable(vec_o));
    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && hold_any) |=> !req_o);
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_PER = 6,
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_n,
    input  logic [N_IRQ-1:0] irq_n,
    input  logic [N_PER-1:0] per_req,
    input  logic             cpu_imask,
    input  logic             cpu_mask_op,
    input  logic             cpu_op_done,
    input  logic             cpu_ack,
    output logic             int_req,
    output logic [VEC_W-1:0] int_vec,
    output logic [VEC_W:0]   int_vaddr,
    output logic             set_imask,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [N_IRQ-1:0] reg_wdata,
    output logic [N_IRQ-1:0] reg_rdata
);
    logic             nmi_pend, nmi_clr, win_any, hold_any;
    logic [N_IRQ-1:0] irq_pend;
    logic [VEC_W-1:0] win_vec;
    intc_state_t      state;

    intc_regs #(.N_IRQ(N_IRQ)) u_regs (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .nmi_clr(nmi_clr), .reg_rdata(reg_rdata),
        .nmi_pend(nmi_pend), .irq_pend(irq_pend)
    );

    intc_prio #(.N_IRQ(N_IRQ), .N_PER(N_PER), .VEC_W(VEC_W)) u_prio (
        .nmi_pend(nmi_pend), .irq_pend(irq_pend), .per_pend(per_req),
        .imask(cpu_imask), .hold(hold_any),
        .win_any(win_any), .win_vec(win_vec)
    );

    intc_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .win_any(win_any), .win_vec(win_vec),
        .cpu_ack(cpu_ack), .mask_op(cpu_mask_op), .op_done(cpu_op_done),
        .req_o(int_req), .vec_o(int_vec), .set_mask_o(set_imask),
        .nmi_clr(nmi_clr), .hold_any(hold_any), .state_o(state)
    );

    assign int_vaddr = {int_vec, 1'b0};

    // R2
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && nmi_pend && !hold_any) |=> (int_req && int_vec == VEC_W'(NMI_VEC)));
    // R5
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(int_req) && $past(cpu_imask)) |-> (int_vec == VEC_W'(NMI_VEC)));
endmodule

// File: tb/sim_intc_top.sv
module sim_intc_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nmi_n = 1'b1;
    logic [7:0] irq_n = 8'hFF;
    logic [5:0] per_req = '0;
    logic       drv_mask = 1'b0;
    logic       mon_mask = 1'b0;
    logic       cpu_imask;
    logic       cpu_mask_op = 1'b0;
    logic       cpu_op_done = 1'b0;
    logic       cpu_ack = 1'b0;
    logic       int_req, set_imask;
    logic [4:0] int_vec;
    logic [5:0] int_vaddr;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int rel_cnt = 0;
    int rel_seen = 0;
    logic mon_busy = 1'b0;
    logic [7:0] rd_val;

    assign cpu_imask = drv_mask | mon_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_top u0 (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n), .per_req(per_req),
        .cpu_imask(cpu_imask), .cpu_mask_op(cpu_mask_op), .cpu_op_done(cpu_op_done),
        .cpu_ack(cpu_ack), .int_req(int_req), .int_vec(int_vec), .int_vaddr(int_vaddr),
        .set_imask(set_imask), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected vector on each offer, acknowledges, checks the grant
    initial begin
        forever begin
            @(negedge clk);
            if (rel_cnt != rel_seen) begin
                mon_mask = 1'b0;
                rel_seen = rel_cnt;
            end
            if (int_req && !cpu_ack) begin
                mon_busy = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5/R10 unexpected offer", int_vec, -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int_vec == e, "R6 vector", int_vec, e);
                    chk(int_vaddr == 2 * e, "R7 vector address", int_vaddr, 2 * e);
                end
                cpu_ack = 1'b1;
                @(negedge clk);
                chk(set_imask == 1'b1, "R8 mask pulse", set_imask, 1);
                chk(int_req == 1'b0, "R8 req dropped", int_req, 0);
                cpu_ack  = 1'b0;
                mon_mask = 1'b1;
                mon_busy = 1'b0;
            end
        end
    end

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || mon_busy) && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, "expected offer missing", exp_q.size(), 0);
        @(negedge clk);
    endtask

    task automatic unmask();
        @(negedge clk);
        rel_cnt++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int_req) ok = 1'b0;
        end
        chk(ok, tag, int_req, 0);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 rd_val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(int_req == 0 && set_imask == 0, "R1 outputs idle", int_req, 0);
        rd(2'd0); chk(rd_val == 8'h00, "R1 sense reset", rd_val, 0);
        rd(2'd1); chk(rd_val == 8'h00, "R1 enable reset", rd_val, 0);

        wr(2'd1, 8'hFF);
        rd(2'd1); chk(rd_val == 8'hFF, "R4 enable readback", rd_val, 255);

        // R3 level-sensed line
        exp_q.push_back(6);
        irq_n[2] = 1'b0;
        drain();
        irq_n[2] = 1'b1;
        unmask();
        quiet(6, "R3 level released");

        // R6 priority among irq and peripheral
        exp_q.push_back(7);
        irq_n[5] = 1'b0; irq_n[3] = 1'b0; per_req[0] = 1'b1;
        drain();
        exp_q.push_back(9);
        irq_n[3] = 1'b1;
        unmask();
        drain();
        exp_q.push_back(12);
        irq_n[5] = 1'b1;
        unmask();
        drain();
        per_req[0] = 1'b0;
        unmask();
        exp_q.push_back(17);
        per_req[5] = 1'b1;
        drain();
        per_req[5] = 1'b0;
        unmask();

        // R2 NMI beats mask and IRQ0
        drv_mask = 1'b1;
        irq_n[0] = 1'b0;
        exp_q.push_back(3);
        nmi_n = 1'b0;
        drain();
        quiet(10, "R2 single acceptance");
        nmi_n = 1'b1; irq_n[0] = 1'b1;
        drv_mask = 1'b0;
        unmask();

        // R5 mask holds off irq
        drv_mask = 1'b1;
        irq_n[1] = 1'b0;
        quiet(10, "R5 masked");
        exp_q.push_back(5);
        drv_mask = 1'b0;
        drain();
        irq_n[1] = 1'b1;
        unmask();

        // R4 disabled line
        wr(2'd1, 8'hFE);
        irq_n[0] = 1'b0;
        quiet(10, "R4 disabled");
        rd(2'd2); chk(rd_val[0] == 1'b1, "R4 status shows", rd_val[0], 1);
        irq_n[0] = 1'b1;
        wr(2'd1, 8'hFF);

        // R3 / R9 edge-sensed line
        wr(2'd0, 8'h50);
        rd(2'd0); chk(rd_val == 8'h50, "R3 sense readback", rd_val, 80);
        exp_q.push_back(8);
        @(negedge clk); irq_n[4] = 1'b0;
        @(negedge clk); irq_n[4] = 1'b1;
        drain();
        wr(2'd2, 8'h00);
        exp_q.push_back(8);
        unmask();
        drain();
        rd(2'd2); chk(rd_val[4] == 1'b1, "R9 flag kept", rd_val[4], 1);
        wr(2'd2, 8'h00);
        rd(2'd2); chk(rd_val[4] == 1'b0, "R9 flag cleared", rd_val[4], 0);
        unmask();
        quiet(8, "R9 no repeat");

        // R10 hold around mask-modifying instruction
        @(negedge clk); cpu_mask_op = 1'b1;
        @(negedge clk); irq_n[6] = 1'b0;
        @(negedge clk); irq_n[6] = 1'b1;
        quiet(4, "R10 hold during op");
        cpu_mask_op = 1'b0;
        quiet(5, "R10 hold until done");
        rd(2'd2); chk(rd_val[6] == 1'b1, "R10 edge captured", rd_val[6], 1);
        exp_q.push_back(10);
        @(negedge clk); cpu_op_done = 1'b1;
        @(negedge clk); cpu_op_done = 1'b0;
        drain();
        wr(2'd2, 8'h00);
        unmask();
        quiet(6, "R10 cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule